// File: doc/BRIEF.md
# Load/Store Address Generation Unit

This unit sits between an instruction decoder and a 32-bit data bus. For each memory access it receives the base register value and an offset. The offset is either a zero-extended immediate or a second register shifted left by a small amount. It adds or subtracts the offset, and picks the bus address according to the indexing mode: pre-indexed uses the sum, post-indexed uses the untouched base. It also computes the updated base value and decides whether that value is written back to the register file.

The unit handles byte, halfword and word sizes. It drives byte-lane enables and replicates store data across the lanes. When the bus returns a word, a separate return path extracts the addressed byte or halfword and zero-extends it. Byte order inside a word is little- or big-endian. The order is captured from a configuration pin while reset is high and stays fixed until the next reset. A halfword or word on an unaligned address, or an access with the reserved size code, raises a fault and cancels both the bus access and the base update.

Top module: `lsagu_top`

## Requirements
- R1: While reset is high, and in the cycle after it, `acc_valid`, `base_wen`, `acc_write` and `ld_valid` are 0.
- R2: In post-indexed mode (`req_pre`=0) `acc_addr` equals `req_base`, `base_next` equals base plus or minus offset, and `base_wen` is 1 whenever no fault is raised.
- R3: In pre-indexed mode (`req_pre`=1) `acc_addr` equals base plus or minus offset. `base_wen` follows `req_wb`, and `base_next` carries the same sum.
- R4: With `req_imm_sel`=1 the offset is `req_imm` zero-extended to the address width. With `req_imm_sel`=0 it is `req_roff` shifted left by `req_shamt`.
- R5: `req_sub`=1 subtracts the offset from the base (modulo 2^32), and `req_sub`=0 adds it.
- R6: Size codes are 00 byte, 01 halfword, 10 word, 11 reserved. A halfword with address bit 0 set, a word with either of the low two address bits set, or the reserved code sets `acc_fault`. A fault forces `acc_be`=0, `acc_write`=0 and `base_wen`=0.
- R7: Lane i is `acc_be[i]` and data bits 8i+7:8i. Little-endian: byte offset k within the word uses lane k. Big-endian: byte offset k uses lane 3-k. A byte sets one lane, a halfword sets two and a word sets four.
- R8: `acc_wdata` holds the low byte of `req_wdata` copied into all four lanes for a byte store. It holds the low halfword copied twice for a halfword store, and `req_wdata` unchanged for a word store. `acc_write` is 1 only for an aligned store (`req_load`=0).
- R9: On the return path, `ld_data` is the byte or halfword at offset `rsp_lo` of `rsp_word`, zero-extended. In big-endian mode the byte at the lower offset is the more significant one. A word comes back unchanged.
- R10: Byte order is sampled from `big_endian_cfg` only while reset is high. Changes to the pin outside reset have no effect.
- R11: Every request appears on the access outputs exactly one cycle after it is presented. Every return appears on `ld_data`/`ld_valid` exactly one cycle after `rsp_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| big_endian_cfg | input | 1 | Byte order captured during reset (1 = big-endian) |
| req_valid | input | 1 | Request present |
| req_load | input | 1 | 1 = load, 0 = store |
| req_size | input | 2 | Access size code |
| req_pre | input | 1 | 1 = pre-indexed, 0 = post-indexed |
| req_wb | input | 1 | Write-back request for pre-indexed mode |
| req_sub | input | 1 | Subtract offset |
| req_imm_sel | input | 1 | Offset source: 1 = immediate, 0 = register |
| req_imm | input | IMM_W | Immediate offset |
| req_roff | input | ADDR_W | Register offset |
| req_shamt | input | SH_W | Left-shift amount for the register offset |
| req_base | input | ADDR_W | Base register value |
| req_wdata | input | 32 | Store data from the register |
| rsp_valid | input | 1 | Bus read data present |
| rsp_lo | input | 2 | Low address bits of the returning load |
| rsp_size | input | 2 | Size code of the returning load |
| rsp_word | input | 32 | Bus read word |
| acc_valid | output | 1 | Access outputs valid |
| acc_addr | output | ADDR_W | Bus byte address |
| acc_be | output | 4 | Byte-lane enables |
| acc_wdata | output | 32 | Lane-aligned store data |
| acc_write | output | 1 | Store to perform |
| acc_fault | output | 1 | Alignment or size fault |
| base_next | output | ADDR_W | Updated base value |
| base_wen | output | 1 | Base register write enable |
| ld_valid | output | 1 | Extracted load data valid |
| ld_data | output | 32 | Zero-extended load value |

## Verification
A wrong latched byte order shows up in the first byte or halfword access after reset. The lane enables move to the mirrored lane and the returned value takes its bytes in reversed order. The bench re-checks this after the configuration pin is toggled outside reset. An adder or mode-select error appears on `acc_addr` or `base_next` one cycle after the faulty request, so every request is scored at that cycle. A missed fault shows up in the same cycle as a write enable or lane enable that should have been suppressed.

// File: rtl/lsagu_pkg.sv
package lsagu_pkg;
  localparam int WORD_W = 32;
  localparam int LANES  = WORD_W / 8;
  localparam int LO_W   = $clog2(LANES);

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_RSVD = 2'b11
  } size_e;
endpackage

// File: rtl/lsagu_offset.sv
// Offset selection, scaling and add/subtract against the base.
module lsagu_offset #(
  parameter int ADDR_W = 32,
  parameter int IMM_W  = 12,
  parameter int SH_W   = 5
) (
  input  logic [ADDR_W-1:0] base,
  input  logic              imm_sel,
  input  logic [IMM_W-1:0]  imm,
  input  logic [ADDR_W-1:0] roff,
  input  logic [SH_W-1:0]   shamt,
  input  logic              sub,
  output logic [ADDR_W-1:0] sum
);
  localparam int PAD_W = ADDR_W - IMM_W;

  logic [ADDR_W-1:0] off;

  always_comb begin
    if (imm_sel) off = {{PAD_W{1'b0}}, imm};
    else         off = roff << shamt;
    sum = sub ? (base - off) : (base + off);
  end
endmodule

// File: rtl/lsagu_lanes.sv
// Lane enables, misalignment detection and store-data replication.
module lsagu_lanes
  import lsagu_pkg::*;
(
  input  logic [LO_W-1:0]   lo,
  input  logic [1:0]        size,
  input  logic              big_end,
  input  logic [WORD_W-1:0] st_data,
  output logic [LANES-1:0]  be,
  output logic [WORD_W-1:0] wdata,
  output logic              misalign
);
  logic [LANES-1:0] be_le;
  logic [LANES-1:0] be_rev;
  size_e            sz;

  always_comb begin
    sz = size_e'(size);
    unique case (sz)
      SZ_BYTE: begin be_le = LANES'(1) << lo; misalign = 1'b0;          end
      SZ_HALF: begin be_le = LANES'(3) << lo; misalign = lo[0];         end
      SZ_WORD: begin be_le = '1;              misalign = (lo != '0);    end
      default: begin be_le = '0;              misalign = 1'b1;          end
    endcase
  end

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign be_rev[i] = be_le[LANES-1-i];
    always_comb begin
      unique case (sz)
        SZ_BYTE: wdata[8*i +: 8] = st_data[7:0];
        SZ_HALF: wdata[8*i +: 8] = st_data[8*(i%2) +: 8];
        default: wdata[8*i +: 8] = st_data[8*i +: 8];
      endcase
    end
  end

  assign be = big_end ? be_rev : be_le;
endmodule

// File: rtl/lsagu_extract.sv
// Picks the addressed byte or halfword out of a returned bus word.
module lsagu_extract
  import lsagu_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  input  logic [LO_W-1:0]   lo,
  input  logic [1:0]        size,
  input  logic              big_end,
  output logic [WORD_W-1:0] value
);
  logic [LO_W-1:0]   sh;
  logic [WORD_W-1:0] shifted;
  size_e             sz;

  always_comb begin
    sz = size_e'(size);
    if (!big_end)           sh = lo;
    else if (sz == SZ_BYTE) sh = LO_W'(LANES-1) - lo;
    else if (sz == SZ_HALF) sh = LO_W'(LANES-2) - lo;
    else                    sh = '0;
    shifted = word >> {sh, 3'b000};
    unique case (sz)
      SZ_BYTE: value = {{(WORD_W-8){1'b0}},  shifted[7:0]};
      SZ_HALF: value = {{(WORD_W-16){1'b0}}, shifted[15:0]};
      default: value = word;
    endcase
  end
endmodule

// File: rtl/lsagu_top.sv
module lsagu_top
  import lsagu_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IMM_W  = 12,
  parameter int SH_W   = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              big_endian_cfg,
  input  logic              req_valid,
  input  logic              req_load,
  input  logic [1:0]        req_size,
  input  logic              req_pre,
  input  logic              req_wb,
  input  logic              req_sub,
  input  logic              req_imm_sel,
  input  logic [IMM_W-1:0]  req_imm,
  input  logic [ADDR_W-1:0] req_roff,
  input  logic [SH_W-1:0]   req_shamt,
  input  logic [ADDR_W-1:0] req_base,
  input  logic [31:0]       req_wdata,
  input  logic              rsp_valid,
  input  logic [1:0]        rsp_lo,
  input  logic [1:0]        rsp_size,
  input  logic [31:0]       rsp_word,
  output logic              acc_valid,
  output logic [ADDR_W-1:0] acc_addr,
  output logic [3:0]        acc_be,
  output logic [31:0]       acc_wdata,
  output logic              acc_write,
  output logic              acc_fault,
  output logic [ADDR_W-1:0] base_next,
  output logic              base_wen,
  output logic              ld_valid,
  output logic [31:0]       ld_data
);
  logic              cfg_be;
  logic [ADDR_W-1:0] sum;
  logic [ADDR_W-1:0] addr_c;
  logic [LANES-1:0]  be_c;
  logic [WORD_W-1:0] wdata_c;
  logic              mis_c;
  logic [WORD_W-1:0] ld_c;

  // Byte order is latched only during reset.
  always_ff @(posedge clk) begin
    if (rst) cfg_be <= big_endian_cfg;
  end

  lsagu_offset #(.ADDR_W(ADDR_W), .IMM_W(IMM_W), .SH_W(SH_W)) u_off (
    .base(req_base), .imm_sel(req_imm_sel), .imm(req_imm), .roff(req_roff),
    .shamt(req_shamt), .sub(req_sub), .sum(sum)
  );

  assign addr_c = req_pre ? sum : req_base;

  lsagu_lanes u_lanes (
    .lo(addr_c[LO_W-1:0]), .size(req_size), .big_end(cfg_be),
    .st_data(req_wdata), .be(be_c), .wdata(wdata_c), .misalign(mis_c)
  );

  lsagu_extract u_ext (
    .word(rsp_word), .lo(rsp_lo), .size(rsp_size), .big_end(cfg_be), .value(ld_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_valid <= 1'b0;
      acc_write <= 1'b0;
      acc_fault <= 1'b0;
      base_wen  <= 1'b0;
      acc_be    <= '0;
      ld_valid  <= 1'b0;
    end else begin
      acc_valid <= req_valid;
      acc_fault <= req_valid & mis_c;
      acc_write <= req_valid & ~req_load & ~mis_c;
      base_wen  <= req_valid & ~mis_c & (~req_pre | req_wb);
      acc_be    <= (req_valid & ~mis_c) ? be_c : '0;
      ld_valid  <= rsp_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (req_valid) begin
      acc_addr  <= addr_c;
      acc_wdata <= wdata_c;
      base_next <= sum;
    end
    if (rsp_valid) ld_data <= ld_c;
  end
endmodule

// File: rtl/lsagu_chk.sv
module lsagu_chk (
  input logic       clk,
  input logic       rst,
  input logic       req_valid,
  input logic       req_load,
  input logic [1:0] req_size,
  input logic       req_pre,
  input logic       req_wb,
  input logic [31:0] req_base,
  input logic       acc_valid,
  input logic [31:0] acc_addr,
  input logic [3:0] acc_be,
  input logic       acc_write,
  input logic       acc_fault,
  input logic       base_wen,
  input logic       rsp_valid,
  input logic       ld_valid
);
  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (!acc_valid && !base_wen && !acc_write && !ld_valid));

  a_r2_post_addr: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && !$past(req_pre)) |-> (acc_addr == $past(req_base)));

  a_r2_post_wb: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && !acc_fault && !$past(req_pre)) |-> base_wen);

  a_r3_pre_wb: assert property (@(posedge clk) disable iff (rst)
    (base_wen && $past(req_pre)) |-> $past(req_wb));

  a_r6_fault_quiet: assert property (@(posedge clk) disable iff (rst)
    acc_fault |-> (!base_wen && acc_be == 4'b0000 && !acc_write));

  a_r7_lane_count: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && !acc_fault) |-> ($countones(acc_be) == (1 << $past(req_size))));

  a_r8_load_no_write: assert property (@(posedge clk) disable iff (rst)
    acc_write |-> !$past(req_load));

  a_r11_req_latency: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> acc_valid);

  a_r11_rsp_latency: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> ld_valid);
endmodule

bind lsagu_top lsagu_chk chk_i (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_load(req_load),
  .req_size(req_size), .req_pre(req_pre), .req_wb(req_wb),
  .req_base(req_base[31:0]), .acc_valid(acc_valid), .acc_addr(acc_addr[31:0]),
  .acc_be(acc_be), .acc_write(acc_write), .acc_fault(acc_fault),
  .base_wen(base_wen), .rsp_valid(rsp_valid), .ld_valid(ld_valid)
);

// File: tb/lsagu_tb.sv
module lsagu_top_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        big_endian_cfg = 1'b0;
  logic        req_valid = 1'b0, req_load = 1'b0, req_pre = 1'b0, req_wb = 1'b0;
  logic        req_sub = 1'b0, req_imm_sel = 1'b0;
  logic [1:0]  req_size = 2'b10;
  logic [11:0] req_imm = '0;
  logic [31:0] req_roff = '0, req_base = '0, req_wdata = '0;
  logic [4:0]  req_shamt = '0;
  logic        rsp_valid = 1'b0;
  logic [1:0]  rsp_lo = '0, rsp_size = '0;
  logic [31:0] rsp_word = '0;
  logic        acc_valid, acc_write, acc_fault, base_wen, ld_valid;
  logic [31:0] acc_addr, acc_wdata, base_next, ld_data;
  logic [3:0]  acc_be;

  always #2.5 clk = ~clk;

  lsagu_top dut_i (.*);

  int checks = 0, errors = 0, cycles = 0;
  bit big_mode = 1'b0;

  typedef struct {
    logic [31:0] addr; logic [3:0] be; logic [31:0] wdata;
    logic write; logic fault; logic [31:0] bnext; logic bwe; string tag;
  } item_t;
  item_t q[$];

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Driver: computes the expected result from the requirements and queues it.
  task automatic send(string tag, bit load, logic [1:0] sz, bit pre, bit wb, bit sub,
                      bit isel, logic [11:0] imm, logic [31:0] roff, logic [4:0] sh,
                      logic [31:0] base, logic [31:0] wd);
    item_t e;
    logic [31:0] off, sum, a;
    int n, lo;
    @(negedge clk);
    off = isel ? {20'd0, imm} : (roff << sh);
    sum = sub ? base - off : base + off;
    a   = pre ? sum : base;
    n   = (sz == 2'b00) ? 1 : (sz == 2'b01) ? 2 : 4;
    lo  = int'(a[1:0]);
    e.tag = tag; e.addr = a; e.bnext = sum;
    e.fault = (sz == 2'b11) || (lo % n != 0);
    e.be = '0;
    if (!e.fault)
      for (int k = 0; k < n; k++) e.be[big_mode ? 3 - (lo + k) : lo + k] = 1'b1;
    e.wdata = (sz == 2'b00) ? {4{wd[7:0]}} : (sz == 2'b01) ? {2{wd[15:0]}} : wd;
    e.write = !load && !e.fault;
    e.bwe   = !e.fault && (!pre || wb);
    req_valid = 1'b1; req_load = load; req_size = sz; req_pre = pre; req_wb = wb;
    req_sub = sub; req_imm_sel = isel; req_imm = imm; req_roff = roff;
    req_shamt = sh; req_base = base; req_wdata = wd;
    q.push_back(e);
  endtask

  task automatic idle();
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // Monitor: scores each access one cycle after its request.
  always @(negedge clk) begin
    if (!rst && acc_valid) begin
      if (q.size() == 0) begin
        chk("R11 unexpected access", 32'd1, 32'd0);
      end else begin
        item_t e;
        e = q.pop_front();
        chk({e.tag, " addr"}, acc_addr, e.addr);
        chk({e.tag, " be"}, {28'd0, acc_be}, {28'd0, e.be});
        chk({e.tag, " fault"}, {31'd0, acc_fault}, {31'd0, e.fault});
        chk({e.tag, " write"}, {31'd0, acc_write}, {31'd0, e.write});
        chk({e.tag, " base_wen"}, {31'd0, base_wen}, {31'd0, e.bwe});
        if (e.bwe) chk({e.tag, " base_next"}, base_next, e.bnext);
        if (e.write) chk({e.tag, " wdata"}, acc_wdata, e.wdata);
      end
    end
  end

  task automatic ret(string tag, logic [1:0] sz, logic [1:0] lo, logic [31:0] w);
    logic [31:0] ev;
    int n;
    n  = (sz == 2'b00) ? 1 : (sz == 2'b01) ? 2 : 4;
    ev = '0;
    for (int k = 0; k < n; k++) begin
      logic [7:0] b;
      int lane;
      lane = big_mode ? 3 - (int'(lo) + k) : int'(lo) + k;
      b = w[8*lane +: 8];
      if (big_mode) ev[8*(n-1-k) +: 8] = b;
      else          ev[8*k +: 8] = b;
    end
    @(negedge clk);
    rsp_valid = 1'b1; rsp_size = sz; rsp_lo = lo; rsp_word = w;
    @(negedge clk);
    rsp_valid = 1'b0;
    chk({tag, " ld_valid"}, {31'd0, ld_valid}, 32'd1);
    chk({tag, " ld_data"}, ld_data, ev);
  endtask

  task automatic do_reset(bit be);
    @(negedge clk);
    rst = 1'b1; big_endian_cfg = be; big_mode = be;
    repeat (3) @(negedge clk);
    chk("R1 acc_valid in reset", {31'd0, acc_valid}, 32'd0);
    chk("R1 base_wen in reset", {31'd0, base_wen}, 32'd0);
    chk("R1 ld_valid in reset", {31'd0, ld_valid}, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 acc_write after reset", {31'd0, acc_write}, 32'd0);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected < 20000", cycles);
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    do_reset(1'b0);
    // R2 post-index, immediate add, word store
    send("R2 post imm word", 0, 2'b10, 0, 0, 0, 1, 12'h010, 0, 0, 32'h1000, 32'hA1B2C3D4);
    // R3 R4 R5 pre-index with write-back, scaled register subtracted
    send("R3 R4 R5 pre scaled sub", 1, 2'b10, 1, 1, 1, 0, 0, 32'd3, 5'd2, 32'h2000, 0);
    // R3 pre-index without write-back
    send("R3 pre no wb", 0, 2'b10, 1, 0, 0, 1, 12'h004, 0, 0, 32'h3000, 32'h11223344);
    // R4 immediate is zero-extended
    send("R4 R5 imm zero-ext", 1, 2'b00, 1, 1, 1, 1, 12'hFFF, 0, 0, 32'h0001_0000, 0);
    // R7 R8 little-endian byte and halfword lanes
    send("R7 R8 le byte lo1", 0, 2'b00, 1, 0, 0, 1, 12'h001, 0, 0, 32'h4000, 32'h0000_005A);
    send("R7 R8 le byte lo3", 0, 2'b00, 0, 0, 0, 1, 12'h000, 0, 0, 32'h4003, 32'h0000_00C3);
    send("R7 R8 le half lo2", 0, 2'b01, 1, 1, 0, 0, 0, 32'h2, 5'd0, 32'h4000, 32'h0000_BEEF);
    // R6 faults
    send("R6 half misaligned", 0, 2'b01, 1, 1, 0, 1, 12'h001, 0, 0, 32'h5000, 32'h1234);
    send("R6 word misaligned post", 0, 2'b10, 0, 0, 0, 1, 12'h004, 0, 0, 32'h5002, 32'h1);
    send("R6 reserved size", 1, 2'b11, 0, 0, 0, 1, 12'h004, 0, 0, 32'h5000, 0);
    // R8 load never writes
    send("R8 load word", 1, 2'b10, 0, 0, 0, 0, 0, 32'h8, 5'd1, 32'h6000, 32'hFFFF_FFFF);
    idle();
    @(negedge clk);
    ret("R9 le byte lo3", 2'b00, 2'd3, 32'hCAFE_1234);
    ret("R9 le half lo2", 2'b01, 2'd2, 32'hCAFE_1234);
    ret("R9 le word", 2'b10, 2'd0, 32'hCAFE_1234);

    do_reset(1'b1);
    @(negedge clk);
    big_endian_cfg = 1'b0;   // R10: ignored outside reset
    send("R7 R10 be byte lo0", 0, 2'b00, 0, 0, 0, 1, 0, 0, 0, 32'h7000, 32'h0000_0077);
    send("R7 be half lo2", 0, 2'b01, 1, 1, 0, 1, 12'h002, 0, 0, 32'h7000, 32'h0000_A55A);
    send("R7 be byte lo2", 1, 2'b00, 0, 0, 0, 1, 0, 0, 0, 32'h7002, 0);
    idle();
    @(negedge clk);
    ret("R9 R10 be byte lo0", 2'b00, 2'd0, 32'h8899_AABB);
    ret("R9 be half lo0", 2'b01, 2'd0, 32'h8899_AABB);
    ret("R9 be half lo2", 2'b01, 2'd2, 32'h8899_AABB);
    repeat (3) @(negedge clk);
    chk("R11 all requests answered", q.size(), 0);
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule